// File: doc/BRIEF.md
# Cascade DAC Update Frame Counter

In a chain of converter devices that share one serial path, every device must load its DAC register in the same cycle. This block runs beside each device's serial port and decides when that load happens. It does not decode an address. It counts the input frame sync strobes that arrive while the device is running. When the count reaches the chain length held in the device-count setting, the word that arrived with that strobe becomes the new DAC value, and the count starts again from zero. On each counted frame before that, the block asks the serial port to pass its held word on to the next device.

The block has three modes. In program mode it does not count at all, and its counter is held at zero. In data mode every received word is a DAC sample and every frame counts. In mixed mode only words whose most significant bit is 0 are DAC samples and count. Words with that bit set are control words: they leave the counter alone and produce no output pulse, so the control decoder can handle them.

Top module: `cascade_dac_sync`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `dac_value` is 0, `fwd_en` is 0 and `dac_upd` is 0, and the frame count is zero.
- R2: In data mode (`run_mode`=1, `mixed_mode`=0), a frame (`fs_in`=1 at a clock edge) whose count stays below the chain length raises `fwd_en` for exactly the one cycle after that edge, and does not change `dac_value`.
- R3: The frame whose count equals the chain length loads its `rx_word` into `dac_value` at that edge. `dac_upd` is high for the following cycle only, and `fwd_en` stays low in that cycle.
- R4: After a load the count is zero, so the next load needs another full set of chain-length frames.
- R5: In mixed mode (`run_mode`=1, `mixed_mode`=1), a frame whose `rx_word` bit 15 is 1 (a control word) leaves the count, `dac_value`, `fwd_en` and `dac_upd` unchanged. A frame whose bit 15 is 0 counts as it does in data mode.
- R6: In program mode (`run_mode`=0), frames are ignored and the count is forced to zero. This takes priority over a frame that arrives in the same cycle.
- R7: A `chain_len` value of 0 means a chain of 2^CNT_W devices (8 by default). A value N from 1 to 7 means N devices.
- R8: With `chain_len`=1, every counted frame loads the DAC register, and `fwd_en` never rises.
- R9: `dac_upd` and `fwd_en` are never high together. Each is high only in the cycle after an edge at which `fs_in` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fs_in | input | 1 | Input frame sync strobe, one cycle per received word |
| rx_word | input | 16 | Word received with the strobe |
| run_mode | input | 1 | 0 = program mode, 1 = data or mixed mode |
| mixed_mode | input | 1 | 1 = mixed mode (used only when `run_mode`=1) |
| chain_len | input | 3 | Device-count setting, where 0 means 8 |
| dac_value | output | 16 | DAC register |
| fwd_en | output | 1 | One-cycle request to forward the held word downstream |
| dac_upd | output | 1 | One-cycle strobe marking a DAC register load |

## Verification
Two events can meet in one clock edge. The first is a frame strobe together with a switch into program mode: the bench drops `run_mode` on the same edge as a frame that would complete the count, and it expects no load, no forward pulse, and a cleared count afterwards. The second is a terminal-count frame followed by the next frame on the very next edge: the bench holds `fs_in` high for consecutive cycles and expects the load and the first forward of the new round in back-to-back cycles. A behavioural model in the bench judges every cycle, and directed checks confirm each requirement.

// File: rtl/cdu_pkg.sv
// Package: shared types for the cascade DAC update frame counter.
// Assumes: nothing beyond the mode inputs of the top module.
package cdu_pkg;
    typedef enum logic [1:0] {
        MODE_PROG  = 2'd0,
        MODE_DATA  = 2'd1,
        MODE_MIXED = 2'd2
    } cdu_mode_e;
endpackage

// File: rtl/cdu_mode_decode.sv
// Module: cdu_mode_decode
// Works out the operating mode and whether the current frame counts.
// Assumes: fs_in is one cycle per received word; word_msb belongs to that word.
module cdu_mode_decode
    import cdu_pkg::*;
(
    input  logic run_mode,
    input  logic mixed_mode,
    input  logic fs_in,
    input  logic word_msb,
    output logic frame_counts,
    output logic hold_clear
);
    cdu_mode_e mode;

    // Map the two mode pins onto one mode value.
    always_comb begin
        if (!run_mode)       mode = MODE_PROG;
        else if (mixed_mode) mode = MODE_MIXED;
        else                 mode = MODE_DATA;
    end

    // Decide whether this frame steps the counter.
    always_comb begin
        unique case (mode)
            MODE_DATA:  frame_counts = fs_in;
            MODE_MIXED: frame_counts = fs_in && !word_msb;
            default:    frame_counts = 1'b0;
        endcase
    end

    // Program mode holds the counter at zero.
    assign hold_clear = (mode == MODE_PROG);
endmodule

// File: rtl/cdu_frame_counter.sv
// Module: cdu_frame_counter
// Counts qualified frames and flags the frame that completes the chain.
// Assumes: a chain_len of 0 encodes 2**CNT_W devices when ZERO_IS_MAX=1;
//          otherwise a chain_len of 0 is taken as 1.
module cdu_frame_counter #(
    parameter int CNT_W       = 3,
    parameter bit ZERO_IS_MAX = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] chain_len,
    output logic             hit
);
    localparam int CW = CNT_W + 1;

    logic [CW-1:0] count;
    logic [CW-1:0] target;
    logic [CW-1:0] count_next;

    // Select how a zero chain length is read.
    generate
        if (ZERO_IS_MAX) begin : g_zero_max
            always_comb target = (chain_len == '0) ? CW'(1) << CNT_W : {1'b0, chain_len};
        end else begin : g_zero_one
            always_comb target = (chain_len == '0) ? CW'(1) : {1'b0, chain_len};
        end
    endgenerate

    // Find the incremented count and whether it completes the chain.
    always_comb begin
        count_next = count + CW'(1);
        hit        = step && !clear && (count_next == target);
    end

    // Counter register: clear on program mode, wrap on the chain's last frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (hit)        count <= '0;
        else if (step)       count <= count_next;
    end
endmodule

// File: rtl/cdu_dac_hold.sv
// Module: cdu_dac_hold
// Holds the DAC register and raises a one-cycle strobe on each load.
// Assumes: load is high for one cycle, together with the word to capture.
module cdu_dac_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] dac_value,
    output logic              dac_upd
);
    // Capture the word on a load; keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    dac_value <= '0;
        else if (load) dac_value <= word;
    end

    // Mark the cycle after a load.
    always_ff @(posedge clk) begin
        if (!rst_n) dac_upd <= 1'b0;
        else        dac_upd <= load;
    end
endmodule

// File: rtl/cascade_dac_sync.sv
// Module: cascade_dac_sync (top)
// Decides when this device loads its DAC register in a chained serial setup.
// It counts qualified frame strobes up to the chain length. It loads on the
// last one and asks for a forward on each earlier one.
// Assumes: serial shifting and control-word decode happen elsewhere.
module cascade_dac_sync #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_in,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              run_mode,
    input  logic              mixed_mode,
    input  logic [CNT_W-1:0]  chain_len,
    output logic [WORD_W-1:0] dac_value,
    output logic              fwd_en,
    output logic              dac_upd
);
    logic frame_counts;
    logic hold_clear;
    logic hit;

    cdu_mode_decode u_mode (
        .run_mode    (run_mode),
        .mixed_mode  (mixed_mode),
        .fs_in       (fs_in),
        .word_msb    (rx_word[WORD_W-1]),
        .frame_counts(frame_counts),
        .hold_clear  (hold_clear)
    );

    cdu_frame_counter #(.CNT_W(CNT_W), .ZERO_IS_MAX(1'b1)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hold_clear),
        .step     (frame_counts),
        .chain_len(chain_len),
        .hit      (hit)
    );

    cdu_dac_hold #(.WORD_W(WORD_W)) u_dac (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hit),
        .word     (rx_word),
        .dac_value(dac_value),
        .dac_upd  (dac_upd)
    );

    // Forward request: a counted frame that does not complete the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) fwd_en <= 1'b0;
        else        fwd_en <= frame_counts && !hold_clear && !hit;
    end
endmodule

// Checker: properties of the frame counter, observed at its ports.
module cdu_checker #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fs_in,
    input logic [WORD_W-1:0] rx_word,
    input logic              run_mode,
    input logic              mixed_mode,
    input logic [CNT_W-1:0]  chain_len,
    input logic [WORD_W-1:0] dac_value,
    input logic              fwd_en,
    input logic              dac_upd
);
    // R9
    upd_fwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dac_upd && fwd_en));
    // R9
    pulse_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_in |=> (!dac_upd && !fwd_en));
    // R3
    dac_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_upd |-> (dac_value == $past(rx_word)));
    // R3
    dac_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_upd && rst_n) |=> (dac_upd || $stable(dac_value)));
    // R6
    prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_mode |=> (!dac_upd && !fwd_en));
    // R5
    ctl_word_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && mixed_mode && fs_in && rx_word[WORD_W-1]) |=> (!dac_upd && !fwd_en));
    // R8
    single_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_len == CNT_W'(1)) |=> !fwd_en);
endmodule

bind cascade_dac_sync cdu_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fs_in(fs_in), .rx_word(rx_word),
    .run_mode(run_mode), .mixed_mode(mixed_mode), .chain_len(chain_len),
    .dac_value(dac_value), .fwd_en(fwd_en), .dac_upd(dac_upd)
);

// File: tb/tb_cascade_dac_sync.sv
// Bench: per-cycle behavioural model plus directed checks per requirement.
module tb_cascade_dac_sync;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs_in = 1'b0;
    logic [15:0] rx_word = '0;
    logic        run_mode = 1'b0;
    logic        mixed_mode = 1'b0;
    logic [2:0]  chain_len = 3'd2;
    logic [15:0] dac_value;
    logic        fwd_en;
    logic        dac_upd;

    int checks = 0;
    int failures = 0;
    string phase = "R1";

    // Model state
    int          m_cnt = 0;
    logic [15:0] m_dac = '0;
    logic        m_fwd = 1'b0;
    logic        m_upd = 1'b0;

    cascade_dac_sync dut (
        .clk(clk), .rst_n(rst_n), .fs_in(fs_in), .rx_word(rx_word),
        .run_mode(run_mode), .mixed_mode(mixed_mode), .chain_len(chain_len),
        .dac_value(dac_value), .fwd_en(fwd_en), .dac_upd(dac_upd)
    );

    always #10 clk = ~clk;

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        int tgt;
        tgt = (chain_len == 3'd0) ? 8 : int'(chain_len);
        if (!rst_n) begin
            m_cnt = 0; m_dac = '0; m_fwd = 0; m_upd = 0;
        end else begin
            m_fwd = 0; m_upd = 0;
            if (!run_mode) m_cnt = 0;
            else if (fs_in && !(mixed_mode && rx_word[15])) begin
                if (m_cnt + 1 == tgt) begin
                    m_dac = rx_word; m_upd = 1; m_cnt = 0;
                end else begin
                    m_cnt = m_cnt + 1; m_fwd = 1;
                end
            end
        end
    end

    // Per-cycle comparison at the falling edge.
    always @(negedge clk) begin
        checks++;
        if (dac_value !== m_dac || fwd_en !== m_fwd || dac_upd !== m_upd) begin
            failures++;
            $display("FAIL %s model: dac=%h fwd=%b upd=%b expected dac=%h fwd=%b upd=%b",
                     phase, dac_value, fwd_en, dac_upd, m_dac, m_fwd, m_upd);
        end
    end

    task automatic expect_out(input string req, input logic [15:0] d,
                              input logic f, input logic u);
        checks++;
        if (dac_value !== d || fwd_en !== f || dac_upd !== u) begin
            failures++;
            $display("FAIL %s: dac=%h fwd=%b upd=%b expected dac=%h fwd=%b upd=%b",
                     req, dac_value, fwd_en, dac_upd, d, f, u);
        end
    endtask

    // One frame: strobe for one cycle, then outputs are valid at the next negedge.
    task automatic frame(input logic [15:0] w);
        @(negedge clk); fs_in = 1'b1; rx_word = w;
        @(negedge clk); fs_in = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset
        idle(3);
        expect_out("R1", 16'h0000, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1", 16'h0000, 0, 0);

        // R2/R3/R4 data mode, chain of two
        phase = "R2"; run_mode = 1; mixed_mode = 0; chain_len = 3'd2;
        frame(16'h1111); expect_out("R2", 16'h0000, 1, 0);
        phase = "R3";
        frame(16'h7FFF); expect_out("R3", 16'h7FFF, 0, 1);
        @(negedge clk);  expect_out("R3", 16'h7FFF, 0, 0);
        phase = "R4";
        frame(16'h2222); expect_out("R4", 16'h7FFF, 1, 0);
        frame(16'h8000); expect_out("R4", 16'h8000, 0, 1);

        // R8 chain of one
        phase = "R8"; chain_len = 3'd1;
        frame(16'h0A0A); expect_out("R8", 16'h0A0A, 0, 1);
        frame(16'h0B0B); expect_out("R8", 16'h0B0B, 0, 1);

        // R7 zero means eight
        phase = "R7"; chain_len = 3'd0;
        for (int i = 0; i < 7; i++) begin
            frame(16'h0100 + 16'(i)); expect_out("R7", 16'h0B0B, 1, 0);
        end
        frame(16'h0C0C); expect_out("R7", 16'h0C0C, 0, 1);

        // R5 mixed mode: control words do not count
        phase = "R5"; mixed_mode = 1; chain_len = 3'd2;
        frame(16'h1234); expect_out("R5", 16'h0C0C, 1, 0);
        frame(16'h9234); expect_out("R5", 16'h0C0C, 0, 0);
        frame(16'hA000); expect_out("R5", 16'h0C0C, 0, 0);
        frame(16'h0456); expect_out("R5", 16'h0456, 0, 1);

        // R6 program mode clears and ignores
        phase = "R6"; mixed_mode = 0;
        frame(16'h0001); expect_out("R6", 16'h0456, 1, 0);
        @(negedge clk); run_mode = 0;
        frame(16'h0002); expect_out("R6", 16'h0456, 0, 0);
        frame(16'h0003); expect_out("R6", 16'h0456, 0, 0);
        @(negedge clk); run_mode = 1;
        frame(16'h0004); expect_out("R6", 16'h0456, 1, 0);
        // Same-cycle: a completing frame while program mode is entered
        @(negedge clk); fs_in = 1; rx_word = 16'h0005; run_mode = 0;
        @(negedge clk); fs_in = 0;
        expect_out("R6", 16'h0456, 0, 0);
        @(negedge clk); run_mode = 1;
        frame(16'h0006); expect_out("R6", 16'h0456, 1, 0);
        frame(16'h0007); expect_out("R6", 16'h0007, 0, 1);

        // R9 back-to-back frames: load then forward in consecutive cycles
        phase = "R9";
        frame(16'h0010); expect_out("R9", 16'h0007, 1, 0);
        @(negedge clk); fs_in = 1; rx_word = 16'h0020;
        @(negedge clk); rx_word = 16'h0030;
        expect_out("R9", 16'h0020, 0, 1);
        @(negedge clk); fs_in = 0;
        expect_out("R9", 16'h0020, 1, 0);
        @(negedge clk);
        expect_out("R9", 16'h0020, 0, 0);

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule